// File: doc/BRIEF.md
# Modem Control and Status Unit

This block holds the modem control byte and builds the modem status byte of a serial port. The host loads the control byte through a one-cycle write strobe. The block drives four active-low handshake outputs (request-to-send, terminal-ready and two auxiliary lines) from that byte. It also samples four active-low handshake inputs (clear-to-send, set-ready, ring and carrier) through a synchroniser. The status byte carries the present level of each input together with sticky change flags. A one-cycle read strobe from the host clears those flags once the host has taken the byte.

A diagnostic loopback mode is selected by a control bit. In this mode the handshake inputs seen by the status logic come from the control bits through a fixed crossover, and the external outputs are parked at their idle level. The serial transmit stream is turned back to the receive side in the same mode. An interrupt request is raised while any change flag is set, and it is gated by the second auxiliary control bit. Baud timing, the character shifter and host address decoding lie outside this block.

Top module: `modem_ctl_stat`

## Requirements
- R1: `ctl_byte` returns the last value written on `wr_data` with bits 7, 6 and 5 forced to 0. Bit 0 is terminal-ready, bit 1 is request-to-send, bit 2 is auxiliary 1, bit 3 is auxiliary 2 and bit 4 is loopback. A write takes effect on the clock edge where `wr_en` is high.
- R2: While loopback is off, each of `dtr_n`, `rts_n`, `out1_n` and `out2_n` is the inverse of control bit 0, 1, 2 and 3 respectively, so writing a 1 drives that pin low.
- R3: While loopback is on, all four handshake outputs and `txd_pin` are held at 1, and `rx_to_core` follows `tx_from_core`. While it is off, `txd_pin` follows `tx_from_core` and `rx_to_core` follows `rxd_pin`.
- R4: While loopback is on, the input levels come from the control bits: clear-to-send from bit 1, set-ready from bit 0, ring from bit 2 and carrier from bit 3. These levels appear in `stat_byte` one edge after the write, and the external input pins have no effect.
- R5: `stat_byte` bits 7, 6, 5 and 4 give the asserted level (1 when the pin is low) of carrier, ring, set-ready and clear-to-send. An external pin change first shows on the third rising edge after it, because of a two-flop synchroniser and a level register.
- R6: `stat_byte` bit 3 (carrier), bit 1 (set-ready) and bit 0 (clear-to-send) become 1 on any change of the matching input level. They stay 1 until a read clears them.
- R7: `stat_byte` bit 2 becomes 1 only when the ring pin goes from low to high, which is the end of a ring. A high-to-low ring edge leaves it unchanged.
- R8: An edge where `rd_stb` is high clears `stat_byte` bits 3 to 0. A change detected on that same edge still sets its flag.
- R9: `irq` is 1 exactly when control bit 3 is 1 and at least one of `stat_byte` bits 3 to 0 is 1.
- R10: After reset, `ctl_byte` and `stat_byte` are 0, `irq` is 0 and the four handshake outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write value |
| ctl_byte | output | 8 | Control byte readback |
| rd_stb | input | 1 | Status read strobe, clears change flags |
| stat_byte | output | 8 | Status byte: levels in 7..4, flags in 3..0 |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Set-ready pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| dcd_n | input | 1 | Carrier pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| out1_n | output | 1 | Auxiliary output 1, active low |
| out2_n | output | 1 | Auxiliary output 2, active low |
| irq | output | 1 | Interrupt request |
| loop_en | output | 1 | Loopback mode active |
| tx_from_core | input | 1 | Serial stream from the transmitter |
| txd_pin | output | 1 | Serial transmit pin |
| rxd_pin | input | 1 | Serial receive pin |
| rx_to_core | output | 1 | Serial stream to the receiver |

## Verification
The bench walks every pair of old and new input pin patterns, once with the interrupt gate open and once with it closed. A design that used the wrong ring edge would show ring flags when a ring starts and miss them when it ends. A wrong latency would show the status early or late. A design that ignored the gate would raise `irq` with auxiliary 2 at 0. The bench also times a change so that it lands on the same edge as a read: a design that lets the clear win drops that event, and the flag reads 0. Every control pattern is run through loopback, which catches a swapped crossover, pins that are not parked, and external inputs that leak into the status.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int NLINES   = 4;
  localparam int BYTE_W   = 8;

  // control bit positions
  localparam int CB_DTR   = 0;
  localparam int CB_RTS   = 1;
  localparam int CB_AUX1  = 2;
  localparam int CB_AUX2  = 3;
  localparam int CB_LOOP  = 4;
  localparam logic [BYTE_W-1:0] CTL_MASK = 8'h1F;

  // line index inside the level / flag nibbles
  localparam int LN_CTS   = 0;
  localparam int LN_DSR   = 1;
  localparam int LN_RING  = 2;
  localparam int LN_CARR  = 3;

  // loopback crossover: control outputs feed the status inputs
  function automatic logic [NLINES-1:0] loop_levels(input logic [BYTE_W-1:0] c);
    logic [NLINES-1:0] r;
    r[LN_CTS]  = c[CB_RTS];
    r[LN_DSR]  = c[CB_DTR];
    r[LN_RING] = c[CB_AUX1];
    r[LN_CARR] = c[CB_AUX2];
    return r;
  endfunction

  // change events: any toggle, except ring which flags only its trailing edge
  function automatic logic [NLINES-1:0] change_events(input logic [NLINES-1:0] prev,
                                                      input logic [NLINES-1:0] cur);
    logic [NLINES-1:0] e;
    e = prev ^ cur;
    e[LN_RING] = prev[LN_RING] & ~cur[LN_RING];
    return e;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(input logic [NLINES-1:0] lvl,
                                                    input logic [NLINES-1:0] flg);
    return {lvl, flg};
  endfunction
endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
  parameter int WIDTH   = 4,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= {CHAIN_W{RST_VAL}};
        else        chain_q <= din;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= {CHAIN_W{RST_VAL}};
        else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], din};
    end
  endgenerate

  assign dout = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/mcs_ctl_reg.sv
module mcs_ctl_reg
  import mcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ctl_q,
  output logic [NLINES-1:0] out_pins_n,
  output logic              loop_on
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= wr_data & CTL_MASK;

  assign loop_on = ctl_q[CB_LOOP];

  // pins indexed by control bit position; parked idle in loopback
  always_comb begin
    for (int i = 0; i < NLINES; i++)
      out_pins_n[i] = loop_on ? 1'b1 : ~ctl_q[i];
  end
endmodule

// File: rtl/mcs_line_track.sv
module mcs_line_track
  import mcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] lvl_in,
  input  logic              rd_clr,
  output logic [NLINES-1:0] lvl_q,
  output logic [NLINES-1:0] flag_q,
  output logic [NLINES-1:0] evt
);
  assign evt = change_events(lvl_q, lvl_in);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_q  <= '0;
      flag_q <= '0;
    end else begin
      lvl_q  <= lvl_in;
      // an event on the read edge wins over the clear
      flag_q <= (flag_q & ~{NLINES{rd_clr}}) | evt;
    end
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
  import mcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] ctl_byte,
  input  logic       rd_stb,
  output logic [7:0] stat_byte,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       rts_n,
  output logic       dtr_n,
  output logic       out1_n,
  output logic       out2_n,
  output logic       irq,
  output logic       loop_en,
  input  logic       tx_from_core,
  output logic       txd_pin,
  input  logic       rxd_pin,
  output logic       rx_to_core
);
  logic [BYTE_W-1:0] ctl_q;
  logic [NLINES-1:0] out_pins_n;
  logic              loop_on;
  logic [NLINES-1:0] pin_raw_n;
  logic [NLINES-1:0] pin_sync_n;
  logic [NLINES-1:0] src_lvl;
  logic [NLINES-1:0] lvl_q;
  logic [NLINES-1:0] flag_q;
  logic [NLINES-1:0] line_evt;

  mcs_ctl_reg u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .ctl_q      (ctl_q),
    .out_pins_n (out_pins_n),
    .loop_on    (loop_on)
  );

  always_comb begin
    pin_raw_n          = '1;
    pin_raw_n[LN_CTS]  = cts_n;
    pin_raw_n[LN_DSR]  = dsr_n;
    pin_raw_n[LN_RING] = ri_n;
    pin_raw_n[LN_CARR] = dcd_n;
  end

  mcs_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pin_raw_n),
    .dout  (pin_sync_n)
  );

  assign src_lvl = loop_on ? loop_levels(ctl_q) : ~pin_sync_n;

  mcs_line_track u_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_in (src_lvl),
    .rd_clr (rd_stb),
    .lvl_q  (lvl_q),
    .flag_q (flag_q),
    .evt    (line_evt)
  );

  assign ctl_byte   = ctl_q;
  assign stat_byte  = pack_status(lvl_q, flag_q);
  assign irq        = ctl_q[CB_AUX2] & (|flag_q);
  assign loop_en    = loop_on;
  assign dtr_n      = out_pins_n[CB_DTR];
  assign rts_n      = out_pins_n[CB_RTS];
  assign out1_n     = out_pins_n[CB_AUX1];
  assign out2_n     = out_pins_n[CB_AUX2];
  assign txd_pin    = loop_on ? 1'b1 : tx_from_core;
  assign rx_to_core = loop_on ? tx_from_core : rxd_pin;
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker
  import mcs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] ctl_byte,
  input logic       rd_stb,
  input logic [7:0] stat_byte,
  input logic       rts_n,
  input logic       dtr_n,
  input logic       out1_n,
  input logic       out2_n,
  input logic       irq,
  input logic       loop_en,
  input logic       tx_from_core,
  input logic       txd_pin,
  input logic       rx_to_core,
  input logic [3:0] line_evt
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_byte[7:5] == 3'b000); // R1

  AST_PIN_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[4]) |=> (rts_n == !$past(wr_data[1]) && dtr_n == !$past(wr_data[0]))); // R2

  AST_LOOP_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (rts_n && dtr_n && out1_n && out2_n && txd_pin)); // R3

  AST_LOOP_RX: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (rx_to_core == tx_from_core)); // R3

  AST_LOOP_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(loop_en) && loop_en) |-> (stat_byte[7:4] == loop_levels($past(ctl_byte)))); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((stat_byte[3:0] & $past(stat_byte[3:0])) == $past(stat_byte[3:0]))); // R6

  AST_RING_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_byte[2]) |-> $fell(stat_byte[6])); // R7

  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (line_evt != 4'b0) |=> ((stat_byte[3:0] & $past(line_evt)) == $past(line_evt))); // R8

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_byte[3] |-> !irq); // R9
endmodule

bind modem_ctl_stat mcs_checker u_mcs_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .ctl_byte     (ctl_byte),
  .rd_stb       (rd_stb),
  .stat_byte    (stat_byte),
  .rts_n        (rts_n),
  .dtr_n        (dtr_n),
  .out1_n       (out1_n),
  .out2_n       (out2_n),
  .irq          (irq),
  .loop_en      (loop_en),
  .tx_from_core (tx_from_core),
  .txd_pin      (txd_pin),
  .rx_to_core   (rx_to_core),
  .line_evt     (line_evt)
);

// File: tb/tb_modem_ctl_stat.sv
module tb_modem_ctl_stat;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] ctl_byte;
  logic       rd_stb = 1'b0;
  logic [7:0] stat_byte;
  logic [3:0] pin_n = 4'hF;   // {carrier, ring, set-ready, clear-to-send}
  logic       rts_n, dtr_n, out1_n, out2_n, irq, loop_en;
  logic       tx_from_core = 1'b1;
  logic       txd_pin;
  logic       rxd_pin = 1'b1;
  logic       rx_to_core;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  modem_ctl_stat dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctl_byte(ctl_byte),
    .rd_stb(rd_stb), .stat_byte(stat_byte),
    .cts_n(pin_n[0]), .dsr_n(pin_n[1]), .ri_n(pin_n[2]), .dcd_n(pin_n[3]),
    .rts_n(rts_n), .dtr_n(dtr_n), .out1_n(out1_n), .out2_n(out2_n), .irq(irq),
    .loop_en(loop_en), .tx_from_core(tx_from_core), .txd_pin(txd_pin),
    .rxd_pin(rxd_pin), .rx_to_core(rx_to_core)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_ctl(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic read_clear();
    rd_stb = 1'b1;
    tick(1);
    rd_stb = 1'b0;
  endtask

  function automatic logic [3:0] out_pins();
    return {out2_n, out1_n, rts_n, dtr_n};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R10 reset state
    chk("R10", "ctl", ctl_byte, 8'h00);
    chk("R10", "stat", stat_byte, 8'h00);
    chk("R10", "pins", {4'h0, out_pins()}, 8'h0F);
    chk("R10", "irq", {7'h0, irq}, 8'h00);

    // R1 reserved bits and readback
    write_ctl(8'hFF);
    chk("R1", "ctl FF", ctl_byte, 8'h1F);
    write_ctl(8'hA6);
    chk("R1", "ctl A6", ctl_byte, 8'h06);
    write_ctl(8'h00);
    tick(2);
    read_clear();
    chk("R8", "cleared after loop exit", stat_byte, 8'h00);

    // R2 pin polarity, every control pattern with loopback off
    for (int v = 0; v < 16; v++) begin
      write_ctl(8'(v));
      chk("R2", "pins", {4'h0, out_pins()}, {4'h0, ~4'(v)});
      tick(1);
      chk("R2", "status untouched", stat_byte, 8'h00);
    end
    write_ctl(8'h00);

    // R3 serial routing
    for (int t = 0; t < 2; t++) begin
      tx_from_core = t[0]; rxd_pin = ~t[0];
      #1;
      chk("R3", "txd normal", {7'h0, txd_pin}, {7'h0, t[0]});
      chk("R3", "rx normal", {7'h0, rx_to_core}, {7'h0, ~t[0]});
    end
    write_ctl(8'h10);
    for (int t = 0; t < 2; t++) begin
      tx_from_core = t[0]; rxd_pin = ~t[0];
      #1;
      chk("R3", "txd loop", {7'h0, txd_pin}, 8'h01);
      chk("R3", "rx loop", {7'h0, rx_to_core}, {7'h0, t[0]});
    end
    chk("R3", "pins parked", {4'h0, out_pins()}, 8'h0F);
    tx_from_core = 1'b1; rxd_pin = 1'b1;

    // R4 loopback crossover for every control pattern
    for (int v = 0; v < 16; v++) begin
      logic [3:0] b;
      logic [3:0] lv;
      b = 4'(v);
      lv = {b[3], b[2], b[0], b[1]};
      write_ctl(8'h10);
      tick(1);
      read_clear();
      write_ctl(8'h10 | 8'(v));
      tick(1);
      chk("R4", "loop levels", stat_byte, {lv, b[3], 1'b0, b[0], b[1]});
      chk("R3", "loop pins", {4'h0, out_pins()}, 8'h0F);
      pin_n = 4'h0;
      tick(4);
      chk("R4", "external ignored", stat_byte[7:4], {4'h0, lv} << 4 >> 4);
      pin_n = 4'hF;
      tick(4);
      read_clear();
      write_ctl(8'h10);
      tick(1);
      chk("R7", "loop ring fall", stat_byte, {4'h0, b[3], b[2], b[0], b[1]});
    end
    write_ctl(8'h00);
    tick(1);
    read_clear();

    // R5..R9 all old/new pin pattern pairs, gate closed then open
    for (int oe = 0; oe < 2; oe++) begin
      write_ctl(8'(oe << 3));
      for (int p = 0; p < 16; p++) begin
        for (int q = 0; q < 16; q++) begin
          logic [3:0] lp, lq, d;
          lp = ~4'(p);
          lq = ~4'(q);
          d[0] = lp[0] != lq[0];
          d[1] = lp[1] != lq[1];
          d[3] = lp[3] != lq[3];
          d[2] = lp[2] && !lq[2];
          pin_n = 4'(p);
          tick(3);
          read_clear();
          chk("R8", "flags clear", {4'h0, stat_byte[3:0]}, 8'h00);
          chk("R5", "old levels", {4'h0, stat_byte[7:4]}, {4'h0, lp});
          pin_n = 4'(q);
          tick(2);
          chk("R5", "latency hold", stat_byte, {lp, 4'h0});
          tick(1);
          chk("R6", "levels and flags", stat_byte, {lq, d});
          chk("R9", "irq", {7'h0, irq}, {7'h0, (oe == 1) && (d != 4'h0)});
        end
      end
    end

    // R8 read on the same edge as a new change
    write_ctl(8'h00);
    pin_n = 4'hF;
    tick(3);
    read_clear();
    pin_n = 4'b1101;
    tick(3);
    chk("R6", "dsr flag", {4'h0, stat_byte[3:0]}, 8'h02);
    pin_n = 4'b1100;
    tick(2);
    rd_stb = 1'b1;
    tick(1);
    rd_stb = 1'b0;
    chk("R8", "same-edge event kept", {4'h0, stat_byte[3:0]}, 8'h01);
    read_clear();
    chk("R8", "later clear", {4'h0, stat_byte[3:0]}, 8'h00);

    finish_run();
  end
endmodule